// File: doc/BRIEF.md
# Deferred Write Holding Stage with Read Forwarding

This block sits between a command decoder and a single-port memory array. It delays the last step of every write. An accepted write is not sent to the array in its own cycle. Its address, both data words and both byte-enable masks are kept in one holding entry. That entry is written to the array only when the next write command arrives, and the new write then becomes the held entry. At most one write is ever waiting, and a run of reads between two writes never competes with a write for the array port.

Reads use the array port in the cycle they are issued. The read address is compared with the held entry, and the result is delivered one cycle later. For each byte, the result takes the held value if that byte was enabled in the held write and the addresses match. Otherwise it takes the value read from the array. Seen from the ports, this makes the block behave like a memory that applies every write at once.

Top module: `posted_wr_buf`

## Requirements
- R1: After reset there is no held entry, `arr_we` is low and `rd_valid` is low.
- R2: A write command is not sent to the array in the cycle it is accepted. The first write after reset leaves `arr_we` low.
- R3: When a write command arrives while an entry is held, `arr_we` is high in that same cycle. `arr_addr`, `arr_wd0`, `arr_wd1`, `arr_be0` and `arr_be1` then carry the held address, data and masks.
- R4: A read command (`rd_req` high, `wr_req` low) drives `arr_re` and `arr_addr` in its own cycle. It produces `rd_valid` high, with its data, in the following cycle.
- R5: On a read whose address matches a valid held entry, every byte enabled in the held write is returned from the held data. Byte-enable bit i covers data bits [8i+7:8i], and enables are active high.
- R6: On a matching read, the bytes not enabled in the held write are returned from the array.
- R7: A read whose address does not match the held entry returns the array contents.
- R8: If `wr_req` and `rd_req` are both high, the write is accepted and the read is dropped: `arr_re` stays low and `rd_valid` is low in the next cycle.
- R9: The held entry stays unchanged through any number of idle or read cycles until the next write.
- R10: A byte whose enable is low in a write keeps its previous value in memory, both after the write is held and after it is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write command |
| rd_req | input | 1 | Read command |
| addr | input | AW | Command address (one location pair) |
| wr_d0 | input | DW | First write word |
| wr_d1 | input | DW | Second write word |
| wr_be0 | input | DW/8 | Byte enables for first word |
| wr_be1 | input | DW/8 | Byte enables for second word |
| arr_we | output | 1 | Array write strobe (commit of held entry) |
| arr_re | output | 1 | Array read strobe |
| arr_addr | output | AW | Array address |
| arr_wd0 | output | DW | Array write word 0 |
| arr_wd1 | output | DW | Array write word 1 |
| arr_be0 | output | DW/8 | Array byte enables, word 0 |
| arr_be1 | output | DW/8 | Array byte enables, word 1 |
| arr_rd0 | input | DW | Array read word 0, one cycle after `arr_re` |
| arr_rd1 | input | DW | Array read word 1, one cycle after `arr_re` |
| rd_valid | output | 1 | Read result valid |
| rd_d0 | output | DW | Read result word 0 |
| rd_d1 | output | DW | Read result word 1 |

## Verification
The hardest case to reach is a read that matches the held entry after an earlier write to the same address has already been committed with a different mask. The result must then mix new held bytes with old array bytes in a particular pattern. The stimulus sets this up with write, read, partial write and read sequences aimed at one address. A long random run then follows over only a few addresses, so such overlaps happen often. Every read result is compared with a memory model in the bench that applies writes immediately.

// File: rtl/posted_wr_buf.sv
module posted_wr_buf #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_d0,
  input  logic [DW-1:0] wr_d1,
  input  logic [BW-1:0] wr_be0,
  input  logic [BW-1:0] wr_be1,
  output logic          arr_we,
  output logic          arr_re,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wd0,
  output logic [DW-1:0] arr_wd1,
  output logic [BW-1:0] arr_be0,
  output logic [BW-1:0] arr_be1,
  input  logic [DW-1:0] arr_rd0,
  input  logic [DW-1:0] arr_rd1,
  output logic          rd_valid,
  output logic [DW-1:0] rd_d0,
  output logic [DW-1:0] rd_d1
);

  logic          hv;
  logic [AW-1:0] ha;
  logic [DW-1:0] hd0, hd1;
  logic [BW-1:0] hb0, hb1;

  logic          rv;
  logic [DW-1:0] sd0, sd1;
  logic [BW-1:0] sb0, sb1;

  wire rd_go = rd_req & ~wr_req;
  wire hit   = hv && (ha == addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv  <= 1'b0;
      ha  <= '0;
      hd0 <= '0;
      hd1 <= '0;
      hb0 <= '0;
      hb1 <= '0;
    end else if (wr_req) begin
      hv  <= 1'b1;
      ha  <= addr;
      hd0 <= wr_d0;
      hd1 <= wr_d1;
      hb0 <= wr_be0;
      hb1 <= wr_be1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv  <= 1'b0;
      sd0 <= '0;
      sd1 <= '0;
      sb0 <= '0;
      sb1 <= '0;
    end else begin
      rv <= rd_go;
      if (rd_go) begin
        sd0 <= hd0;
        sd1 <= hd1;
        sb0 <= hit ? hb0 : '0;
        sb1 <= hit ? hb1 : '0;
      end
    end
  end

  assign arr_we   = wr_req & hv;
  assign arr_re   = rd_go;
  assign arr_addr = wr_req ? ha : addr;
  assign arr_wd0  = hd0;
  assign arr_wd1  = hd1;
  assign arr_be0  = hb0;
  assign arr_be1  = hb1;
  assign rd_valid = rv;

  for (genvar g = 0; g < BW; g++) begin : g_merge
    assign rd_d0[8*g +: 8] = sb0[g] ? sd0[8*g +: 8] : arr_rd0[8*g +: 8];
    assign rd_d1[8*g +: 8] = sb1[g] ? sd1[8*g +: 8] : arr_rd1[8*g +: 8];
  end

endmodule

// File: rtl/posted_wr_buf_chk.sv
module posted_wr_buf_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          arr_we,
  input logic          arr_re,
  input logic          rd_valid,
  input logic          hv,
  input logic [AW-1:0] ha
);

  // R3
  commit_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wr_req);

  // R2
  write_becomes_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> hv);

  // R9
  held_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv && !wr_req) |=> (hv && $stable(ha)));

  // R4
  read_result_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req) |=> rd_valid);

  // R8
  collided_read_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !rd_valid);

  // R8
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_we, arr_re}));

endmodule

bind posted_wr_buf posted_wr_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
  .arr_we(arr_we), .arr_re(arr_re), .rd_valid(rd_valid),
  .hv(hv), .ha(ha)
);

// File: tb/tb_posted_wr_buf.sv
module tb_posted_wr_buf;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NL = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 0, rd_req = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_d0 = '0, wr_d1 = '0;
  logic [BW-1:0] wr_be0 = '0, wr_be1 = '0;
  logic arr_we, arr_re, rd_valid;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wd0, arr_wd1, arr_rd0, arr_rd1, rd_d0, rd_d1;
  logic [BW-1:0] arr_be0, arr_be1;

  always #2 clk = ~clk;

  posted_wr_buf #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req), .addr(addr),
    .wr_d0(wr_d0), .wr_d1(wr_d1), .wr_be0(wr_be0), .wr_be1(wr_be1),
    .arr_we(arr_we), .arr_re(arr_re), .arr_addr(arr_addr),
    .arr_wd0(arr_wd0), .arr_wd1(arr_wd1), .arr_be0(arr_be0), .arr_be1(arr_be1),
    .arr_rd0(arr_rd0), .arr_rd1(arr_rd1),
    .rd_valid(rd_valid), .rd_d0(rd_d0), .rd_d1(rd_d1));

  logic [DW-1:0] mem0 [NL];
  logic [DW-1:0] mem1 [NL];
  logic [DW-1:0] ref0 [NL];
  logic [DW-1:0] ref1 [NL];

  always_ff @(posedge clk) begin
    if (arr_we)
      for (int i = 0; i < BW; i++) begin
        if (arr_be0[i]) mem0[arr_addr][8*i +: 8] <= arr_wd0[8*i +: 8];
        if (arr_be1[i]) mem1[arr_addr][8*i +: 8] <= arr_wd1[8*i +: 8];
      end
    if (arr_re) begin
      arr_rd0 <= mem0[arr_addr];
      arr_rd1 <= mem1[arr_addr];
    end
  end

  int errors = 0, checks = 0;
  bit done = 0;

  bit            pv = 0;
  int            pa;
  logic [DW-1:0] pd0, pd1;
  logic [BW-1:0] pb0, pb1;
  bit            erv = 0;
  logic [DW-1:0] ed0, ed1;
  string         etag = "";

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input bit r, input int a,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input logic [BW-1:0] m0, input logic [BW-1:0] m1, input string tag);
    @(negedge clk);
    chk(rd_valid == erv, {etag, " rd_valid"}, DW'(rd_valid), DW'(erv));
    if (erv) begin
      chk(rd_d0 === ed0, {etag, " word0"}, rd_d0, ed0);
      chk(rd_d1 === ed1, {etag, " word1"}, rd_d1, ed1);
    end
    wr_req = w; rd_req = r; addr = AW'(a);
    wr_d0 = d0; wr_d1 = d1; wr_be0 = m0; wr_be1 = m1;
    #1;
    chk(arr_we == (w && pv), (w && pv) ? "R3 commit strobe" : "R2 no early commit",
        DW'(arr_we), DW'(w && pv));
    chk(arr_re == (r && !w), "R8/R4 read strobe", DW'(arr_re), DW'(r && !w));
    if (w && pv) begin
      chk(arr_addr == AW'(pa), "R3 commit addr", DW'(arr_addr), DW'(pa));
      chk(arr_wd0 == pd0 && arr_wd1 == pd1, "R3 commit data", arr_wd0 ^ arr_wd1, pd0 ^ pd1);
      chk(arr_be0 == pb0 && arr_be1 == pb1, "R3 commit masks",
          DW'({arr_be0, arr_be1}), DW'({pb0, pb1}));
    end
    if (r && !w) chk(arr_addr == AW'(a), "R4 read addr", DW'(arr_addr), DW'(a));
    erv = r && !w;
    etag = tag;
    if (erv) begin ed0 = ref0[a]; ed1 = ref1[a]; end
    if (w) begin
      for (int i = 0; i < BW; i++) begin
        if (m0[i]) ref0[a][8*i +: 8] = d0[8*i +: 8];
        if (m1[i]) ref1[a][8*i +: 8] = d1[8*i +: 8];
      end
      pv = 1; pa = a; pd0 = d0; pd1 = d1; pb0 = m0; pb1 = m1;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, '0, '0, '0, '0, "idle");
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      mem0[i] = '0; mem1[i] = '0; ref0[i] = '0; ref1[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_valid == 0, "R1 rd_valid in reset", DW'(rd_valid), 0);
    rst_n = 1'b1;
    #1;
    chk(arr_we == 0, "R1 arr_we after reset", DW'(arr_we), 0);
    // R2: first write held, not committed
    step(1, 0, 3, 32'h11223344, 32'h55667788, 4'hF, 4'hF, "R2");
    // R5: read hit from held entry
    step(0, 1, 3, '0, '0, '0, '0, "R5 full hit");
    // R7: miss returns array
    step(0, 1, 5, '0, '0, '0, '0, "R7 miss");
    // R3 + R6: partial write commits prior, then read merges
    step(1, 0, 3, 32'hAABBCCDD, 32'hEEFF0011, 4'b0101, 4'b1000, "R3");
    step(0, 1, 3, '0, '0, '0, '0, "R6 merge");
    // R10: commit partial, read back from array
    step(1, 0, 9, 32'h01020304, 32'h05060708, 4'hF, 4'hF, "R10");
    step(0, 1, 3, '0, '0, '0, '0, "R10 masked bytes kept");
    // R8: simultaneous write and read
    step(1, 1, 3, 32'hCAFEF00D, 32'hDEADBEEF, 4'b0010, 4'b0001, "R8");
    step(0, 1, 3, '0, '0, '0, '0, "R8 write applied");
    // R9: held entry persists across idle and reads
    idle(20);
    step(0, 1, 7, '0, '0, '0, '0, "R9 miss");
    step(0, 1, 3, '0, '0, '0, '0, "R9 held hit");
    // back-to-back write-read-write-read same address
    step(1, 0, 3, 32'h0000FFFF, 32'hFFFF0000, 4'b1100, 4'b0011, "R3");
    step(0, 1, 3, '0, '0, '0, '0, "R5 wrw read1");
    step(1, 0, 3, 32'h12345678, 32'h9ABCDEF0, 4'b0001, 4'b1110, "R3");
    step(0, 1, 3, '0, '0, '0, '0, "R6 wrw read2");
    // random run over few addresses
    for (int n = 0; n < 2000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      step(op < 4 || op == 9, op >= 4, $urandom_range(0, 3),
           $urandom, $urandom, BW'($urandom), BW'($urandom), "R5/R6/R7 random");
    end
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule